// File: doc/BRIEF.md
# Dual-Bank Interrupt Event Controller

This block gathers interrupt reports from many peripheral sources into two banks of 32-bit state and drives one interrupt request toward a processor. Each source belongs to one of two groups, device or DMA, and reports a new line state together with a one-hot identifier. The block routes the identifier to a bit of one bank, keeps a mirror of every line's current level, and latches an event bit for that source. The capture rule comes from a mode bit held in the primary bank's mask register. Native capture records only rising transitions. Emulation capture records every reported transition.

Events are filtered by each bank's mask at all times, so a masked source never holds a pending event. Software reads and writes the banks through a small word-addressed register port, and it drops pending events by writing ones to a write-only clear register. The OR of all pending events is registered as the request line. That line is then gated with the processor's interrupt-enable bit, so an already-pending request is delivered in the same cycle the enable goes high.

Source reports arrive on a valid/ready stream. The block never applies back-pressure: `src_ready` is high whenever reset is released, so a report is consumed on every rising clock edge where `src_valid` is high. The register port and the enable/request pins are plain control signals.

Top module: `irq_event_hub`

## Requirements
- R1: For every consumed report, the level bit of the routed source becomes 1 if `src_state` is 1 and 0 if it is 0, visible from the next clock edge.
- R2: With mask bit 31 of the primary bank clear (native capture), a report sets the source's event bit only when `src_state` is 1 and its level bit was 0. Every other report from that source clears the bit.
- R3: With mask bit 31 of the primary bank set (emulation capture), every report sets the source's event bit, whatever its direction.
- R4: The capture mode is read from bit 31 of the primary mask register (offset 5): 1 selects emulation, 0 selects native. The mode applies to both banks.
- R5: An event bit whose mask bit is 0 reads as 0 in every cycle. This includes the cycle after software clears a mask bit that had a pending event.
- R6: A device report with identifier at or above 1<<20 updates the secondary bank at bits `id >> 10`. A lower device identifier updates the primary bank at bits `id << 11`.
- R7: A DMA report with identifier at or above 1<<10 updates the secondary bank at bits `id >> 10`. A lower DMA identifier updates the primary bank at bits `id` unshifted.
- R8: `irq_req` is a register that equals the OR of all event bits of both banks as they stood one clock earlier. It rises on the second edge after the report that creates the event.
- R9: `cpu_irq` is high only while `cpu_ie` is high. When `cpu_ie` rises while `irq_req` is high, `cpu_irq` is high in that same cycle, with no clock edge needed.
- R10: Writing a word to a clear register (offset 2 secondary, 6 primary) clears every event bit written as 1. If a report for one of those bits is consumed in the same cycle, the report's result wins.
- R11: Word offsets 0 to 7 map to: secondary events, mask, clear, levels; then primary events, mask, clear, levels. Reads are combinational, mask registers read back what was written, clear registers read 0, and writes to event and level offsets have no effect.
- R12: After reset, all registers and `irq_req` are 0, and `src_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | A source report is offered |
| src_ready | output | 1 | Report accepted (always 1 out of reset) |
| src_is_dma | input | 1 | Report comes from the DMA group (1) or the device group (0) |
| src_id | input | 32 | One-hot source identifier |
| src_state | input | 1 | New line state of the source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cpu_ie | input | 1 | Processor external-interrupt enable |
| irq_req | output | 1 | Registered OR of all pending events |
| cpu_irq | output | 1 | Request gated by `cpu_ie` |

## Verification
The bound checker watches several things on every cycle: that no event bit survives outside its mask, that a primary-bank device report lands in the level register, that native capture of a falling report leaves no event, and that emulation capture sets the masked event bit. It also checks the one-cycle registration of the request, the enable gate on `cpu_irq`, and the zero read of the clear offsets. The directed scenarios are what cover the routing to the secondary bank and of DMA sources, the clear-versus-report collision in one cycle, the ignoring of writes to event and level offsets, and repeated same-state reports in both capture modes. Those cases depend on sequences of register writes and reports that a single property does not express.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

  // Two bits select the field within a bank, one more bit selects the bank.
  localparam int unsigned FIELD_W   = 2;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned ADDR_W    = FIELD_W + $clog2(NUM_BANKS);

  // Bank index equals the top address bit: secondary at 0..3, primary at 4..7.
  localparam int unsigned BANK_SEC = 0;
  localparam int unsigned BANK_PRI = 1;

  typedef enum logic [FIELD_W-1:0] {
    FLD_EVENTS = 2'd0,
    FLD_MASK   = 2'd1,
    FLD_CLEAR  = 2'd2,
    FLD_LEVELS = 2'd3
  } reg_field_e;

  function automatic logic [ADDR_W-1:0] reg_offset(input int unsigned bank,
                                                   input reg_field_e fld);
    return {bank[ADDR_W-FIELD_W-1:0], fld};
  endfunction

endpackage

// File: rtl/irq_src_router.sv
module irq_src_router
  import irq_evt_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEV_SPLIT  = 20,
  parameter int unsigned DEV_HI_SHR = 10,
  parameter int unsigned DEV_LO_SHL = 11,
  parameter int unsigned DMA_SPLIT  = 10,
  parameter int unsigned DMA_HI_SHR = 10
) (
  input  logic                             valid_i,
  input  logic                             is_dma_i,
  input  logic [DATA_W-1:0]                id_i,
  output logic [NUM_BANKS-1:0]             upd_o,
  output logic [NUM_BANKS-1:0][DATA_W-1:0] bits_o
);

  localparam logic [DATA_W-1:0] DEV_LIM = DATA_W'(1) << DEV_SPLIT;
  localparam logic [DATA_W-1:0] DMA_LIM = DATA_W'(1) << DMA_SPLIT;

  logic to_sec;

  always_comb begin
    to_sec = is_dma_i ? (id_i >= DMA_LIM) : (id_i >= DEV_LIM);

    upd_o             = '0;
    upd_o[BANK_SEC]   = valid_i && to_sec;
    upd_o[BANK_PRI]   = valid_i && !to_sec;

    bits_o[BANK_SEC]  = is_dma_i ? (id_i >> DMA_HI_SHR) : (id_i >> DEV_HI_SHR);
    bits_o[BANK_PRI]  = is_dma_i ? id_i : (id_i << DEV_LO_SHL);
  end

endmodule

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emul_i,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] upd_bits_i,
  input  logic              upd_state_i,
  input  logic              mask_we_i,
  input  logic              clr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ev_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] lev_o
);

  logic [DATA_W-1:0] ev_q, mask_q, lev_q;
  logic [DATA_W-1:0] ev_cleared, set_pat, ev_upd, mask_d, ev_d, lev_d;

  always_comb begin
    // Software clear is applied first so that a same-cycle report overrides it.
    ev_cleared = clr_we_i ? (ev_q & ~wdata_i) : ev_q;

    // Bits that end up set among those the report touches.
    if (emul_i)           set_pat = '1;
    else if (upd_state_i) set_pat = ~lev_q;
    else                  set_pat = '0;

    ev_upd = upd_i ? ((ev_cleared & ~upd_bits_i) | (upd_bits_i & set_pat))
                   : ev_cleared;

    mask_d = mask_we_i ? wdata_i : mask_q;
    ev_d   = ev_upd & mask_d;

    if (!upd_i)           lev_d = lev_q;
    else if (upd_state_i) lev_d = lev_q | upd_bits_i;
    else                  lev_d = lev_q & ~upd_bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
      lev_q  <= '0;
    end else begin
      ev_q   <= ev_d;
      mask_q <= mask_d;
      lev_q  <= lev_d;
    end
  end

  assign ev_o   = ev_q;
  assign mask_o = mask_q;
  assign lev_o  = lev_q;

endmodule

// File: rtl/irq_event_hub.sv
module irq_event_hub
  import irq_evt_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MODE_BIT   = 31,
  parameter int unsigned DEV_SPLIT  = 20,
  parameter int unsigned DEV_HI_SHR = 10,
  parameter int unsigned DEV_LO_SHL = 11,
  parameter int unsigned DMA_SPLIT  = 10,
  parameter int unsigned DMA_HI_SHR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic              src_is_dma,
  input  logic [DATA_W-1:0] src_id,
  input  logic              src_state,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cpu_ie,
  output logic              irq_req,
  output logic              cpu_irq
);

  logic [NUM_BANKS-1:0]             bank_upd;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_bits;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_ev, bank_mask, bank_lev;
  logic                             emul_mode;
  logic                             irq_q;
  logic                             rd_bank;
  reg_field_e                       rd_field;

  assign src_ready = rst_n;
  assign emul_mode = bank_mask[BANK_PRI][MODE_BIT];

  irq_src_router #(
    .DATA_W    (DATA_W),
    .DEV_SPLIT (DEV_SPLIT),
    .DEV_HI_SHR(DEV_HI_SHR),
    .DEV_LO_SHL(DEV_LO_SHL),
    .DMA_SPLIT (DMA_SPLIT),
    .DMA_HI_SHR(DMA_HI_SHR)
  ) u_router (
    .valid_i (src_valid && src_ready),
    .is_dma_i(src_is_dma),
    .id_i    (src_id),
    .upd_o   (bank_upd),
    .bits_o  (bank_bits)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic mask_we, clr_we;
    assign mask_we = reg_we && (reg_addr == reg_offset(b, FLD_MASK));
    assign clr_we  = reg_we && (reg_addr == reg_offset(b, FLD_CLEAR));

    irq_evt_bank #(.DATA_W(DATA_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .emul_i     (emul_mode),
      .upd_i      (bank_upd[b]),
      .upd_bits_i (bank_bits[b]),
      .upd_state_i(src_state),
      .mask_we_i  (mask_we),
      .clr_we_i   (clr_we),
      .wdata_i    (reg_wdata),
      .ev_o       (bank_ev[b]),
      .mask_o     (bank_mask[b]),
      .lev_o      (bank_lev[b])
    );
  end

  // Combinational register read.
  always_comb begin
    rd_bank  = reg_addr[ADDR_W-1];
    rd_field = reg_field_e'(reg_addr[FIELD_W-1:0]);
    case (rd_field)
      FLD_EVENTS: reg_rdata = bank_ev[rd_bank];
      FLD_MASK:   reg_rdata = bank_mask[rd_bank];
      FLD_LEVELS: reg_rdata = bank_lev[rd_bank];
      default:    reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |bank_ev;
  end

  assign irq_req = irq_q;
  assign cpu_irq = irq_q && cpu_ie;

endmodule

// File: rtl/irq_event_hub_sva.sv
module irq_event_hub_sva #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MODE_BIT   = 31,
  parameter int unsigned DEV_SPLIT  = 20,
  parameter int unsigned DEV_LO_SHL = 11
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   src_valid,
  input logic                   src_ready,
  input logic                   src_is_dma,
  input logic [DATA_W-1:0]      src_id,
  input logic                   src_state,
  input logic                   reg_we,
  input logic [2:0]             reg_addr,
  input logic [DATA_W-1:0]      reg_rdata,
  input logic                   cpu_ie,
  input logic                   irq_req,
  input logic                   cpu_irq,
  input logic [1:0][DATA_W-1:0] ev,
  input logic [1:0][DATA_W-1:0] mk,
  input logic [1:0][DATA_W-1:0] lv
);

  localparam logic [DATA_W-1:0] DEV_LIM = DATA_W'(1) << DEV_SPLIT;

  function automatic logic [DATA_W-1:0] pri_bits(input logic [DATA_W-1:0] id);
    return id << DEV_LO_SHL;
  endfunction

  logic dev_pri_rep;
  assign dev_pri_rep = src_valid && src_ready && !src_is_dma &&
                       (src_id != '0) && (src_id < DEV_LIM) && !reg_we;

  AST_SRC_READY: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready) else $error("src_ready low"); // R12

  AST_PRI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[1] & ~mk[1]) == '0) else $error("primary event outside mask"); // R5

  AST_SEC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[0] & ~mk[0]) == '0) else $error("secondary event outside mask"); // R5

  AST_LEVEL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    dev_pri_rep |=> ((lv[1] & pri_bits($past(src_id))) != '0) == $past(src_state))
    else $error("level mirror wrong"); // R1

  AST_NATIVE_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_pri_rep && !mk[1][MODE_BIT] && !src_state)
      |=> (ev[1] & pri_bits($past(src_id))) == '0)
    else $error("native low report left event"); // R2

  AST_EMUL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_pri_rep && mk[1][MODE_BIT])
      |=> (ev[1] & pri_bits($past(src_id))) == (pri_bits($past(src_id)) & mk[1]))
    else $error("emulation report did not set event"); // R3

  AST_IRQ_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_req == $past((ev[0] != '0) || (ev[1] != '0)))
    else $error("irq_req not registered OR"); // R8

  AST_GATE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> cpu_ie) else $error("cpu_irq without enable"); // R9

  AST_GATE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ie && irq_req) |-> cpu_irq) else $error("pending request not delivered"); // R9

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd2 || reg_addr == 3'd6) |-> reg_rdata == '0)
    else $error("clear offset read nonzero"); // R11

endmodule

bind irq_event_hub irq_event_hub_sva #(
  .DATA_W    (DATA_W),
  .MODE_BIT  (MODE_BIT),
  .DEV_SPLIT (DEV_SPLIT),
  .DEV_LO_SHL(DEV_LO_SHL)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_valid (src_valid),
  .src_ready (src_ready),
  .src_is_dma(src_is_dma),
  .src_id    (src_id),
  .src_state (src_state),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .cpu_ie    (cpu_ie),
  .irq_req   (irq_req),
  .cpu_irq   (cpu_irq),
  .ev        (bank_ev),
  .mk        (bank_mask),
  .lv        (bank_lev)
);

// File: tb/tb_irq_event_hub.sv
`timescale 1ns/1ps
module tb_irq_event_hub;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic        src_is_dma = 1'b0;
  logic [31:0] src_id = '0;
  logic        src_state = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_ie = 1'b0;
  logic        irq_req;
  logic        cpu_irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_event_hub dut (
    .clk(clk), .rst_n(rst_n),
    .src_valid(src_valid), .src_ready(src_ready), .src_is_dma(src_is_dma),
    .src_id(src_id), .src_state(src_state),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_ie(cpu_ie), .irq_req(irq_req), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_valid = 1'b0; reg_we = 1'b0; cpu_ie = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic report(input logic dma, input logic [31:0] id, input logic st);
    src_is_dma = dma; src_id = id; src_state = st; src_valid = 1'b1;
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr_and_report(input logic [2:0] a, input logic [31:0] d,
                               input logic [31:0] id, input logic st);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    src_is_dma = 1'b0; src_id = id; src_state = st; src_valid = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; src_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #0.5;
    chk(req, reg_rdata, exp);
  endtask

  task automatic t_reset_state();
    do_reset();
    for (int a = 0; a < 8; a++) rd_chk("R12 reset reg", 3'(a), 32'h0);
    chk("R12 irq_req after reset", {31'b0, irq_req}, 32'h0);
    chk("R12 src_ready", {31'b0, src_ready}, 32'h1);
  endtask

  task automatic t_native();
    do_reset();
    wr(3'd5, 32'h0000_0800);
    report(1'b0, 32'h1, 1'b1);
    rd_chk("R2 native rise sets event", 3'd4, 32'h800);
    rd_chk("R1 level set", 3'd7, 32'h800);
    chk("R8 irq_req latency", {31'b0, irq_req}, 32'h0);
    @(negedge clk);
    chk("R8 irq_req raised", {31'b0, irq_req}, 32'h1);
    chk("R9 gated off", {31'b0, cpu_irq}, 32'h0);
    cpu_ie = 1'b1;
    #0.5;
    chk("R9 immediate on enable", {31'b0, cpu_irq}, 32'h1);
    @(negedge clk);
    cpu_ie = 1'b0;
    report(1'b0, 32'h1, 1'b1);
    rd_chk("R2 repeated high clears event", 3'd4, 32'h0);
    rd_chk("R1 level still high", 3'd7, 32'h800);
    report(1'b0, 32'h1, 1'b0);
    rd_chk("R1 level cleared", 3'd7, 32'h0);
    rd_chk("R2 fall leaves no event", 3'd4, 32'h0);
    @(negedge clk);
    chk("R8 irq_req dropped", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_emulation();
    do_reset();
    wr(3'd5, 32'h8000_0800);
    rd_chk("R11 mask readback", 3'd5, 32'h8000_0800);
    report(1'b0, 32'h1, 1'b0);
    rd_chk("R3 R4 low report sets event", 3'd4, 32'h800);
    wr(3'd6, 32'h0000_0800);
    rd_chk("R10 clear drops event", 3'd4, 32'h0);
    rd_chk("R11 clear reads zero", 3'd6, 32'h0);
    report(1'b0, 32'h1, 1'b1);
    report(1'b0, 32'h1, 1'b1);
    rd_chk("R3 repeated high keeps event", 3'd4, 32'h800);
    rd_chk("R1 emulation level", 3'd7, 32'h800);
  endtask

  task automatic t_mask();
    do_reset();
    wr(3'd5, 32'h8000_0000);
    report(1'b0, 32'h2, 1'b1);
    rd_chk("R5 masked source no event", 3'd4, 32'h0);
    rd_chk("R1 masked source level", 3'd7, 32'h1000);
    wr(3'd5, 32'h8000_1000);
    report(1'b0, 32'h2, 1'b0);
    rd_chk("R5 unmasked event", 3'd4, 32'h1000);
    wr(3'd5, 32'h8000_0000);
    rd_chk("R5 mask removal drops event", 3'd4, 32'h0);
    @(negedge clk);
    chk("R5 no request left", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_device_route();
    do_reset();
    wr(3'd1, 32'h0000_0400);
    wr(3'd5, 32'h4000_0000);
    report(1'b0, 32'h0010_0000, 1'b1);
    rd_chk("R6 high device to secondary event", 3'd0, 32'h400);
    rd_chk("R6 high device to secondary level", 3'd3, 32'h400);
    rd_chk("R6 primary untouched", 3'd4, 32'h0);
    report(1'b0, 32'h0008_0000, 1'b1);
    rd_chk("R6 low device to primary event", 3'd4, 32'h4000_0000);
    rd_chk("R6 low device to primary level", 3'd7, 32'h4000_0000);
  endtask

  task automatic t_dma_route();
    do_reset();
    wr(3'd5, 32'h1);
    wr(3'd1, 32'h1);
    report(1'b1, 32'h1, 1'b1);
    rd_chk("R7 low dma unshifted", 3'd4, 32'h1);
    rd_chk("R7 secondary untouched", 3'd0, 32'h0);
    report(1'b1, 32'h0000_0400, 1'b1);
    rd_chk("R7 high dma to secondary event", 3'd0, 32'h1);
    rd_chk("R7 high dma to secondary level", 3'd3, 32'h1);
    report(1'b1, 32'h0000_0200, 1'b1);
    rd_chk("R7 dma bit9 level", 3'd7, 32'h201);
    rd_chk("R7 dma bit9 masked", 3'd4, 32'h1);
  endtask

  task automatic t_collision_and_ignored();
    do_reset();
    wr(3'd5, 32'h0000_1800);
    report(1'b0, 32'h1, 1'b1);
    report(1'b0, 32'h1, 1'b0);
    report(1'b0, 32'h2, 1'b1);
    rd_chk("R10 setup event", 3'd4, 32'h1000);
    wr_and_report(3'd6, 32'h0000_1800, 32'h1, 1'b1);
    rd_chk("R10 report wins over clear", 3'd4, 32'h800);
    rd_chk("R10 levels after collision", 3'd7, 32'h1800);
    wr(3'd4, 32'hFFFF_FFFF);
    rd_chk("R11 event write ignored", 3'd4, 32'h800);
    wr(3'd7, 32'h0);
    rd_chk("R11 level write ignored", 3'd7, 32'h1800);
    wr(3'd3, 32'hFFFF_FFFF);
    rd_chk("R11 secondary level write ignored", 3'd3, 32'h0);
  endtask

  initial begin
    t_reset_state();
    t_native();
    t_emulation();
    t_mask();
    t_device_route();
    t_dma_route();
    t_collision_and_ignored();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule